// File: doc/BRIEF.md
# SCSI Handshake Timeout Monitor

This block watches the REQ/ACK handshake of a parallel SCSI bus and the busy state of the surrounding controller. When a response takes longer than its programmed limit, it raises a sticky timeout flag. The handshake watch follows the controller's role and transfer mode. An asynchronous target times from its own REQ rising to the initiator's ACK rising. An asynchronous initiator times from its ACK rising to the target dropping REQ. A synchronous target times from each REQ it sends until the outstanding offset count falls to zero.

Two further timers share the same counting core. One spaces out retries of a failed selection or reselection and gives a single-cycle ready pulse when the wait is over. The other delays the strobe that tells the bus driver to assert REQ or ACK after data becomes ready in an asynchronous transfer. Role, mode and limits are static configuration and change only while the handshake is idle. Bus drivers, phase control and data movement are handled elsewhere.

Top module: `scsi_hsk_monitor`

## Requirements
- R1: After reset, `hsk_to`, `busy_to`, `retry_rdy` and `drive_go` are all low. Each of `req_in` and `ack_in` passes through a two-flop synchronizer, and its edges are taken from the synchronized value. An edge on a pin is therefore recognized on the third rising clock after the pin changes.
- R2: In asynchronous mode as target (`mode_sync`=0, `role_tgt`=1), timing starts on a recognized REQ rise and stops on a recognized ACK rise. `hsk_to` sets only if ACK rises more than `lim_hsk` clocks after REQ.
- R3: In asynchronous mode as initiator (`mode_sync`=0, `role_tgt`=0), timing starts on a recognized ACK rise and stops on a recognized REQ fall. `hsk_to` sets only if REQ falls more than `lim_hsk` clocks after ACK rose.
- R4: In synchronous mode as target (`mode_sync`=1, `role_tgt`=1), timing starts on a recognized REQ rise and stops at the first clock on which `offset_cnt` (sampled directly) is zero. `hsk_to` sets only if that clock is more than `lim_hsk` clocks after the REQ rise was recognized.
- R5: In synchronous mode as initiator, `hsk_to` never sets.
- R6: `busy_to` sets once `busy` has been high for `lim_busy`+1 consecutive clocks. A shorter busy period leaves it low.
- R7: After `retry_start` is sampled high, `retry_rdy` pulses high for exactly one cycle, `lim_retry` clocks later. A new `retry_start` restarts the wait.
- R8: After `data_rdy` is sampled high, `drive_go` pulses for one cycle. In asynchronous mode the pulse comes `dly_cfg` clocks later, or 1 clock later when `dly_cfg` is 0. In synchronous mode it always comes 1 clock later.
- R9: A limit of zero disables its timeout. With `lim_hsk`, `lim_busy` or `lim_retry` at zero, the matching flag or pulse never appears.
- R10: `hsk_to` and `busy_to` stay set until a one-cycle `clr`. If a new timeout and `clr` arrive on the same clock, the flag stays set.
- R11: Every new start condition restarts the count from zero. A second REQ rise before ACK measures the response time from the later REQ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 1 | REQ line as seen on the bus, asynchronous |
| ack_in | input | 1 | ACK line as seen on the bus, asynchronous |
| role_tgt | input | 1 | 1 = target, 0 = initiator |
| mode_sync | input | 1 | 1 = synchronous transfer, 0 = asynchronous |
| offset_cnt | input | 6 | Outstanding synchronous offset (REQs not yet acknowledged) |
| busy | input | 1 | Controller busy flag |
| lim_hsk | input | 16 | Handshake limit in clocks, 0 = off |
| lim_busy | input | 16 | Busy limit in clocks, 0 = off |
| lim_retry | input | 16 | Retry interval in clocks, 0 = off |
| dly_cfg | input | 16 | Asynchronous REQ/ACK assertion delay in clocks |
| retry_start | input | 1 | Pulse: selection or reselection failed, start retry wait |
| data_rdy | input | 1 | Pulse: data ready, start assertion delay |
| clr | input | 1 | Pulse: clear both timeout flags |
| hsk_to | output | 1 | Sticky handshake timeout |
| busy_to | output | 1 | Sticky busy timeout |
| retry_rdy | output | 1 | One-cycle pulse: retry allowed |
| drive_go | output | 1 | One-cycle pulse: assert REQ/ACK now |

## Verification
The assertions check the rules that hold on every cycle. Flags stay set without `clr`, and a same-cycle timeout beats `clr`. `busy_to` can only rise after `busy` was high, and `hsk_to` never rises in synchronous initiator mode. `retry_rdy` and `drive_go` never last two cycles. A start always restarts the count, and the synchronizer front only rises after its pin did. The exact timeout boundary needs the bench's scenarios. A response at exactly the limit must stay quiet, and one clock later it must flag. The same scenarios cover the role and mode pairs with their edge choices, the restart on a repeated REQ, the zero-limit cases and the exact cycle of each pulse.

// File: rtl/hsk_mon_pkg.sv
// Package: shared widths and the REQ/ACK pair type for the handshake monitor.
// Assumes: nothing; holds only constants and types.
package hsk_mon_pkg;
    localparam int LIM_W_DEF = 16;
    localparam int OFS_W_DEF = 6;

    // One bit per handshake line, used for levels and edges alike.
    typedef struct packed {
        logic req;
        logic ack;
    } hsk_pair_t;
endpackage

// File: rtl/hsk_sync_edge.sv
// Module: multi-stage synchronizer with rise/fall detection per bit.
// Assumes: STAGES >= 2; din is asynchronous to clk; edges are one-cycle
// pulses derived from the last synchronizer stage.
module hsk_sync_edge #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    localparam int TOP = STAGES - 1;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the pin through the chain and keep the previous output level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
                last  <= chain[TOP];
            end
        end

        assign lvl[b]  = chain[TOP];
        assign rise[b] = chain[TOP] & ~last;
        assign fall[b] = ~chain[TOP] & last;

        // R1: the first stage only rises after the pin was high.
        a_r1_front_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chain[0]) |-> $past(din[b]));
    end
endmodule

// File: rtl/hsk_span_timer.sv
// Module: restartable interval timer that fires once per start.
// Assumes: start restarts the count at zero; stop ends a run quietly;
// hit is combinational and marks the clock on which the run reaches limit;
// a zero limit never runs and never hits.
module hsk_span_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         stop,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic         run;
    logic [W-1:0] cnt;
    logic [W:0]   next_cnt;
    logic         lim_on;

    assign lim_on   = (limit != '0);
    assign next_cnt = {1'b0, cnt} + 1'b1;
    assign hit      = run && lim_on && !start && !stop && (next_cnt >= {1'b0, limit});

    // Run-state and count: start beats stop, stop beats counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= lim_on;
            cnt <= '0;
        end else if (stop) begin
            run <= 1'b0;
        end else if (run) begin
            if (hit) run <= 1'b0;
            else     cnt <= next_cnt[W-1:0];
        end
    end

    // R11: a start always begins a fresh run from zero.
    a_r11_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit != '0) |=> (run && cnt == '0));
    // R9: a zero limit leaves the timer idle.
    a_r9_zero_limit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit == '0) |=> !run);
endmodule

// File: rtl/scsi_hsk_monitor.sv
// Module: REQ/ACK handshake, busy and retry timeout monitor with the
// asynchronous assertion-delay strobe.
// Assumes: role_tgt, mode_sync and the limits change only while the
// handshake is idle; offset_cnt is synchronous to clk; clr, retry_start
// and data_rdy are single-cycle strobes.
module scsi_hsk_monitor
    import hsk_mon_pkg::*;
#(
    parameter int LIM_W  = LIM_W_DEF,
    parameter int OFS_W  = OFS_W_DEF,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic             ack_in,
    input  logic             role_tgt,
    input  logic             mode_sync,
    input  logic [OFS_W-1:0] offset_cnt,
    input  logic             busy,
    input  logic [LIM_W-1:0] lim_hsk,
    input  logic [LIM_W-1:0] lim_busy,
    input  logic [LIM_W-1:0] lim_retry,
    input  logic [LIM_W-1:0] dly_cfg,
    input  logic             retry_start,
    input  logic             data_rdy,
    input  logic             clr,
    output logic             hsk_to,
    output logic             busy_to,
    output logic             retry_rdy,
    output logic             drive_go
);
    localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

    hsk_pair_t pin_v, lvl_v, rise_v, fall_v;
    logic      hsk_start, hsk_stop, hit_hsk;
    logic      busy_q, busy_start, hit_busy;
    logic      hit_retry, hit_go;
    logic [LIM_W-1:0] go_lim;

    assign pin_v = '{req: req_in, ack: ack_in};

    hsk_sync_edge #(.N(2), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_v),
        .lvl  (lvl_v),
        .rise (rise_v),
        .fall (fall_v)
    );

    // Pick the start/stop edge pair for the current role and mode.
    always_comb begin
        unique case ({mode_sync, role_tgt})
            2'b01:   begin hsk_start = rise_v.req; hsk_stop = rise_v.ack;         end
            2'b00:   begin hsk_start = rise_v.ack; hsk_stop = fall_v.req;         end
            2'b11:   begin hsk_start = rise_v.req; hsk_stop = (offset_cnt == '0); end
            default: begin hsk_start = 1'b0;       hsk_stop = 1'b1;               end
        endcase
    end

    hsk_span_timer #(.W(LIM_W)) u_hsk_tmr (
        .clk(clk), .rst_n(rst_n), .start(hsk_start), .stop(hsk_stop),
        .limit(lim_hsk), .hit(hit_hsk)
    );

    // Remember last busy level to find the start of a busy period.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    assign busy_start = busy & ~busy_q;

    hsk_span_timer #(.W(LIM_W)) u_busy_tmr (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .stop(~busy),
        .limit(lim_busy), .hit(hit_busy)
    );

    hsk_span_timer #(.W(LIM_W)) u_retry_tmr (
        .clk(clk), .rst_n(rst_n), .start(retry_start), .stop(1'b0),
        .limit(lim_retry), .hit(hit_retry)
    );

    assign go_lim = (mode_sync || dly_cfg == '0) ? ONE : dly_cfg;

    hsk_span_timer #(.W(LIM_W)) u_go_tmr (
        .clk(clk), .rst_n(rst_n), .start(data_rdy), .stop(1'b0),
        .limit(go_lim), .hit(hit_go)
    );

    // Sticky flags: a new timeout wins over a clear on the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsk_to  <= 1'b0;
            busy_to <= 1'b0;
        end else begin
            if (hit_hsk)  hsk_to <= 1'b1;
            else if (clr) hsk_to <= 1'b0;
            if (hit_busy) busy_to <= 1'b1;
            else if (clr) busy_to <= 1'b0;
        end
    end

    // Register the single-cycle retry and drive strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_rdy <= 1'b0;
            drive_go  <= 1'b0;
        end else begin
            retry_rdy <= hit_retry;
            drive_go  <= hit_go;
        end
    end

    // R10: flags hold until cleared.
    a_r10_hsk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hsk_to && !clr) |=> hsk_to);
    a_r10_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_to && !clr) |=> busy_to);
    // R10: a timeout on the clearing clock still leaves the flag set.
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hsk |=> hsk_to);
    // R6: the busy flag only rises after busy was sampled high.
    a_r6_busy_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_to) |-> $past(busy));
    // R5: no handshake timeout appears in synchronous initiator mode.
    a_r5_sync_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsk_to) |-> !$past(mode_sync && !role_tgt));
    // R7: retry-ready is a single-cycle pulse.
    a_r7_retry_single: assert property (@(posedge clk) disable iff (!rst_n)
        retry_rdy |=> !retry_rdy);
    // R8: the drive strobe is a single-cycle pulse.
    a_r8_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        drive_go |=> !drive_go);
endmodule

// File: tb/test_scsi_hsk_monitor.sv
`timescale 1ns/1ps
module test_scsi_hsk_monitor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_in, ack_in, role_tgt, mode_sync, busy;
    logic [5:0]  offset_cnt;
    logic [15:0] lim_hsk, lim_busy, lim_retry, dly_cfg;
    logic        retry_start, data_rdy, clr;
    logic        hsk_to, busy_to, retry_rdy, drive_go;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    scsi_hsk_monitor i_scsi_hsk_monitor (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in),
        .role_tgt(role_tgt), .mode_sync(mode_sync), .offset_cnt(offset_cnt),
        .busy(busy), .lim_hsk(lim_hsk), .lim_busy(lim_busy),
        .lim_retry(lim_retry), .dly_cfg(dly_cfg), .retry_start(retry_start),
        .data_rdy(data_rdy), .clr(clr), .hsk_to(hsk_to), .busy_to(busy_to),
        .retry_rdy(retry_rdy), .drive_go(drive_go)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Expected handshake flag from the requirements (R2..R5, R9).
    function automatic logic exp_hsk(input bit tgt, input bit syn, input int lim, input int d);
        if (syn && !tgt) return 1'b0;
        return (lim != 0) && (d > lim);
    endfunction

    // Expected drive delay in clocks (R8).
    function automatic int exp_go(input bit syn, input int dly);
        return (syn || dly == 0) ? 1 : dly;
    endfunction

    task automatic pulse_clr();
        clr = 1'b1; step(); clr = 1'b0; step();
    endtask

    // One handshake scenario; d = response clocks after the start edge.
    task automatic hsk_trial(input string tag, input bit tgt, input bit syn,
                             input int lim, input int d);
        lim_hsk = 16'(lim); role_tgt = tgt; mode_sync = syn;
        req_in = !tgt; ack_in = 1'b0; offset_cnt = 6'd5;
        repeat (6) step();
        pulse_clr();
        chk({tag, " R10 cleared"}, hsk_to, 1'b0);
        if (!syn && tgt)       begin req_in = 1'b1; repeat (d) step(); ack_in = 1'b1; end
        else if (!syn && !tgt) begin ack_in = 1'b1; repeat (d) step(); req_in = 1'b0; end
        else                   begin req_in = 1'b1; repeat (d + 2) step(); offset_cnt = '0; end
        repeat (lim + 8) step();
        chk(tag, hsk_to, exp_hsk(tgt, syn, lim, d));
        req_in = 1'b0; ack_in = 1'b0; offset_cnt = 6'd5;
        repeat (6) step();
    endtask

    task automatic busy_trial(input string tag, input int lim, input int h);
        lim_busy = 16'(lim);
        pulse_clr();
        busy = 1'b1; repeat (h) step(); busy = 1'b0;
        repeat (3) step();
        chk(tag, busy_to, (lim != 0) && (h > lim));
    endtask

    // Strobe at N0; pulse expected exactly at negedge N(1+lat).
    task automatic retry_trial(input string tag, input int lim);
        lim_retry = 16'(lim);
        retry_start = 1'b1; step(); retry_start = 1'b0;
        for (int k = 1; k <= lim + 3; k++) begin
            chk(tag, retry_rdy, (lim != 0) && (k == lim + 1));
            step();
        end
    endtask

    task automatic go_trial(input string tag, input bit syn, input int dly);
        int lat;
        mode_sync = syn; dly_cfg = 16'(dly);
        lat = exp_go(syn, dly);
        step();
        data_rdy = 1'b1; step(); data_rdy = 1'b0;
        for (int k = 1; k <= lat + 3; k++) begin
            chk(tag, drive_go, k == lat + 1);
            step();
        end
    endtask

    initial begin
        void'($urandom(32'h5C51_0604));
        rst_n = 1'b0; req_in = 1'b0; ack_in = 1'b0; role_tgt = 1'b1;
        mode_sync = 1'b0; offset_cnt = 6'd5; busy = 1'b0;
        lim_hsk = 16'd4; lim_busy = 16'd4; lim_retry = 16'd4; dly_cfg = 16'd3;
        retry_start = 1'b0; data_rdy = 1'b0; clr = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset hsk_to", hsk_to, 1'b0);
        chk("R1 reset busy_to", busy_to, 1'b0);
        chk("R1 reset retry_rdy", retry_rdy, 1'b0);
        chk("R1 reset drive_go", drive_go, 1'b0);

        // Directed boundaries: at the limit stays quiet, one past flags.
        hsk_trial("R2 async tgt at limit", 1, 0, 6, 6);
        hsk_trial("R2 async tgt over limit", 1, 0, 6, 7);
        hsk_trial("R1 R2 async tgt fast ack", 1, 0, 3, 1);
        hsk_trial("R3 async init at limit", 0, 0, 5, 5);
        hsk_trial("R3 async init over limit", 0, 0, 5, 6);
        hsk_trial("R4 sync tgt drained in time", 1, 1, 8, 8);
        hsk_trial("R4 sync tgt drained late", 1, 1, 8, 9);
        hsk_trial("R5 sync init never flags", 0, 1, 2, 20);
        hsk_trial("R9 zero hsk limit", 1, 0, 0, 30);

        // R11: second REQ rise restarts the handshake count.
        lim_hsk = 16'd10; role_tgt = 1'b1; mode_sync = 1'b0;
        pulse_clr();
        req_in = 1'b1; repeat (4) step(); req_in = 1'b0; repeat (4) step();
        req_in = 1'b1; repeat (9) step(); ack_in = 1'b1; repeat (20) step();
        chk("R11 restart on new REQ", hsk_to, 1'b0);
        req_in = 1'b0; ack_in = 1'b0; repeat (6) step();

        busy_trial("R6 busy at limit", 7, 7);
        busy_trial("R6 busy over limit", 7, 8);
        busy_trial("R9 zero busy limit", 0, 40);
        busy_trial("R6 busy limit one", 1, 2);
        // R10: flag stays without clear, then one clr drops it.
        repeat (5) step();
        chk("R10 busy sticky", busy_to, 1'b1);
        clr = 1'b1; step(); clr = 1'b0;
        chk("R10 clear drops flag", busy_to, 1'b0);

        retry_trial("R7 retry interval 5", 5);
        retry_trial("R7 retry interval 1", 1);
        retry_trial("R9 zero retry limit", 0);
        // R7: a second strobe restarts the wait.
        lim_retry = 16'd5;
        retry_start = 1'b1; step(); retry_start = 1'b0; step(); step();
        retry_start = 1'b1; step(); retry_start = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            chk("R7 retry restart", retry_rdy, k == 6);
            step();
        end

        go_trial("R8 async delay 4", 0, 4);
        go_trial("R8 async delay 0 acts as 1", 0, 0);
        go_trial("R8 sync ignores delay", 1, 9);

        // Random handshake mix against the requirement model.
        for (int i = 0; i < 40; i++) begin
            bit tgt, syn;
            int lim, d;
            tgt = 1'($urandom_range(1, 0));
            syn = 1'($urandom_range(3, 0) == 0);
            lim = $urandom_range(20, 0);
            d   = $urandom_range(30, 1);
            hsk_trial($sformatf("R2 R3 R4 R5 random #%0d t%0b s%0b l%0d d%0d",
                                i, tgt, syn, lim, d), tgt, syn, lim, d);
        end
        for (int i = 0; i < 10; i++) begin
            int lim, h;
            lim = $urandom_range(12, 0);
            h   = $urandom_range(16, 1);
            busy_trial($sformatf("R6 random busy l%0d h%0d", lim, h), lim, h);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule